// File: doc/BRIEF.md
# Stereo Slot-Framed Serial Word Receiver

This block turns two serial bit streams, one per stereo channel, into parallel 16-bit two's-complement words. Both channels are sampled at the same instants on their own pins, driven by a slow data clock. A frame strobe marks the slot that starts each word. Sixteen slots follow, one bit per slot. The sign bit travels in the first slot, and the remaining bits follow from most to least significant.

Each finished pair of words is handed to the faster system clock domain. There it appears on two parallel buses together with a single-cycle valid strobe. The same path also serves setup words, such as coefficients and counts, because they use the identical slot format. If a new frame strobe arrives partway through a word, the partial bits are thrown away and capture starts again.

Top module: `stereo_slot_rx`

## Requirements
- R1: While `rst_n` is low, and after its release until the first completed word, `word_vld` is 0 and both word outputs are 0.
- R2: A word begins at the data-clock rising edge where `frame_in` is 1; that slot is slot 0. Slot s (0 to 15) is sampled on the s-th rising edge after it, and its bit lands in output bit 15-s. Slot 0 is therefore the sign bit and slot 15 is bit 0.
- R3: Left and right channels are sampled on the same edges and delivered in the same `word_vld` strobe. Each channel comes only from its own pin.
- R4: Each completed 16-slot word produces exactly one `word_vld` pulse, and that pulse lasts exactly one system clock cycle.
- R5: `word_l` and `word_r` change only in a cycle where `word_vld` is 1. Between pulses they hold the last delivered pair.
- R6: If `frame_in` is 1 again before slot 15 has been sampled, the partial word is discarded without a pulse. The edge carrying the new frame becomes slot 0 of a new word.
- R7: Data-clock edges after slot 15 with `frame_in` at 0 are ignored: no pulse, and the outputs keep their values.
- R8: Every 16-bit pattern passes through unaltered, including 0x8000, 0x7FFF, 0xFFFF and 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock, must be several times faster than `dclk` |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| dclk | input | 1 | Serial data clock; bits are sampled on its rising edge |
| frame_in | input | 1 | High in the slot that starts a word |
| sdat_l | input | 1 | Left channel serial data |
| sdat_r | input | 1 | Right channel serial data |
| word_l | output | 16 | Last completed left word, two's complement |
| word_r | output | 16 | Last completed right word, two's complement |
| word_vld | output | 1 | One system-clock pulse when a new pair is presented |

## Verification
The embedded properties check several things on every clock. In the data-clock domain they confirm that a frame strobe always restarts the slot count, and that an idle tracker stays idle and does not signal completion without a frame. In the system domain they confirm that the valid pulse never lasts two cycles and that the outputs hold still between pulses. Other behaviour can only be shown by the bench's stimulus against a separately computed expectation: the mapping of slots to bit positions, the channel separation, the dropping of a partial word, and the exact bit patterns at the signed extremes.

// File: rtl/slot_rx_pkg.sv
package slot_rx_pkg;

  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned CH_LEFT  = 0;
  localparam int unsigned CH_RIGHT = 1;

  // width of a counter that must represent 0..slots (slots = idle marker)
  function automatic int unsigned slot_cnt_width(input int unsigned slots);
    return $clog2(slots + 1);
  endfunction

endpackage

// File: rtl/slot_tracker.sv
module slot_tracker #(
  parameter int unsigned SLOTS = 16
) (
  input  logic dclk,
  input  logic rst_n,
  input  logic frame_in,
  output logic shift_en,
  output logic word_done,
  output logic done_tgl
);
  localparam int unsigned CW = slot_rx_pkg::slot_cnt_width(SLOTS);
  localparam logic [CW-1:0] IDLE = CW'(SLOTS);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  // number of slots already taken for the current word; IDLE when none open
  logic [CW-1:0] slot_cnt;

  assign shift_en  = frame_in || (slot_cnt < IDLE);
  assign word_done = !frame_in && (slot_cnt == LAST);

  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt <= IDLE;
      done_tgl <= 1'b0;
    end else begin
      if (frame_in)            slot_cnt <= ONE;
      else if (slot_cnt < IDLE) slot_cnt <= slot_cnt + ONE;
      if (word_done)           done_tgl <= ~done_tgl;
    end
  end

  // R6: a frame strobe always opens a fresh word at slot 0
  a_r6_frame_restart: assert property (@(posedge dclk) disable iff (!rst_n)
    frame_in |=> (slot_cnt == ONE));

  // R7: with no frame, an idle tracker stays idle and signals nothing
  a_r7_idle_quiet: assert property (@(posedge dclk) disable iff (!rst_n)
    (slot_cnt == IDLE && !frame_in) |=> (slot_cnt == IDLE && $stable(done_tgl)));

  // R4: completion closes the word
  a_r4_done_closes: assert property (@(posedge dclk) disable iff (!rst_n)
    word_done |=> (slot_cnt == IDLE));

endmodule

// File: rtl/slot_shift.sv
module slot_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              dclk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              word_done,
  input  logic              sdat,
  output logic [WORD_W-1:0] word_hold
);
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shreg_next;

  // earliest slot ends up in the top bit after WORD_W shifts
  assign shreg_next = {shreg[WORD_W-2:0], sdat};

  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      word_hold <= '0;
    end else begin
      if (shift_en)  shreg     <= shreg_next;
      if (word_done) word_hold <= shreg_next;
    end
  end

endmodule

// File: rtl/toggle_sync.sv
module toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= tgl_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= chain[STAGES-1];
  end

  assign pulse = chain[STAGES-1] ^ seen;

  // R4: the source toggles at most once per word, far apart
  a_r4_pulse_gap: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

endmodule

// File: rtl/stereo_slot_rx.sv
module stereo_slot_rx #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic              dclk,
  input  logic              frame_in,
  input  logic              sdat_l,
  input  logic              sdat_r,
  output logic [WORD_W-1:0] word_l,
  output logic [WORD_W-1:0] word_r,
  output logic              word_vld
);
  import slot_rx_pkg::*;

  logic                          shift_en;
  logic                          word_done;
  logic                          done_tgl;
  logic                          cap_pulse;
  logic [NUM_CH-1:0]             sdat_v;
  logic [NUM_CH-1:0][WORD_W-1:0] hold;

  assign sdat_v[CH_LEFT]  = sdat_l;
  assign sdat_v[CH_RIGHT] = sdat_r;

  slot_tracker #(.SLOTS(WORD_W)) u_trk (
    .dclk      (dclk),
    .rst_n     (rst_n),
    .frame_in  (frame_in),
    .shift_en  (shift_en),
    .word_done (word_done),
    .done_tgl  (done_tgl)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    slot_shift #(.WORD_W(WORD_W)) u_sh (
      .dclk      (dclk),
      .rst_n     (rst_n),
      .shift_en  (shift_en),
      .word_done (word_done),
      .sdat      (sdat_v[ch]),
      .word_hold (hold[ch])
    );
  end

  toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (sys_clk),
    .rst_n (rst_n),
    .tgl_in(done_tgl),
    .pulse (cap_pulse)
  );

  // hold registers are stable for many system cycles around the pulse
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      word_vld <= 1'b0;
      word_l   <= '0;
      word_r   <= '0;
    end else begin
      word_vld <= cap_pulse;
      if (cap_pulse) begin
        word_l <= hold[CH_LEFT];
        word_r <= hold[CH_RIGHT];
      end
    end
  end

  // R5: outputs move only together with the valid strobe
  a_r5_hold_between: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !word_vld |-> ($stable(word_l) && $stable(word_r)));

  // R4: strobe is a single cycle
  a_r4_single_cycle: assert property (@(posedge sys_clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

endmodule

// File: tb/sim_stereo_slot_rx.sv
module sim_stereo_slot_rx;
  localparam int SYS_PERIOD = 10;
  localparam int DCLK_HALF  = 4 * SYS_PERIOD;
  localparam int SETTLE     = 12;

  logic        sys_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        dclk    = 1'b0;
  logic        frame_in = 1'b0;
  logic        sdat_l = 1'b0;
  logic        sdat_r = 1'b0;
  logic [15:0] word_l;
  logic [15:0] word_r;
  logic        word_vld;

  int total = 0;
  int fails = 0;
  int vld_cnt = 0;
  int wide_cnt = 0;
  logic prev_vld = 1'b0;
  bit done_flag = 1'b0;

  always #(SYS_PERIOD/2) sys_clk = ~sys_clk;

  stereo_slot_rx u0 (
    .sys_clk (sys_clk), .rst_n (rst_n), .dclk (dclk), .frame_in (frame_in),
    .sdat_l (sdat_l), .sdat_r (sdat_r),
    .word_l (word_l), .word_r (word_r), .word_vld (word_vld)
  );

  always @(negedge sys_clk) begin
    if (word_vld) begin
      vld_cnt++;
      if (prev_vld) wide_cnt++;
    end
    prev_vld = word_vld;
  end

  // slot s holds bit (15-s) of the delivered value
  function automatic logic [15:0] slots_to_word(input logic [15:0] slots);
    logic [15:0] w = '0;
    for (int s = 0; s < 16; s++) w[15-s] = slots[s];
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dclk_bit(input logic fr, input logic bl, input logic br);
    frame_in = fr; sdat_l = bl; sdat_r = br;
    #(DCLK_HALF); dclk = 1'b1;
    #(DCLK_HALF); dclk = 1'b0;
  endtask

  // send n slots; slot s carries sl[s]/sr[s]
  task automatic send_slots(input logic [15:0] sl, input logic [15:0] sr, input int n, input bit with_frame);
    for (int s = 0; s < n; s++) dclk_bit(with_frame && s == 0, sl[s], sr[s]);
    frame_in = 1'b0;
  endtask

  task automatic expect_pair(input logic [15:0] sl, input logic [15:0] sr, input int base, input string req);
    repeat (SETTLE) @(negedge sys_clk);
    check(vld_cnt == base + 1, {req, " pulse count"}, vld_cnt, base + 1);
    check(word_l == slots_to_word(sl), {req, " left"}, word_l, slots_to_word(sl));
    check(word_r == slots_to_word(sr), {req, " right"}, word_r, slots_to_word(sr));
  endtask

  task automatic word_case(input logic [15:0] vl, input logic [15:0] vr, input string req);
    int base;
    logic [15:0] sl, sr;
    sl = slots_to_word(vl);  // bit reversal is its own inverse
    sr = slots_to_word(vr);
    base = vld_cnt;
    send_slots(sl, sr, 16, 1'b1);
    expect_pair(sl, sr, base, req);
  endtask

  initial begin
    int unsigned seed_v;
    int base;
    logic [15:0] keep_l, keep_r;
    seed_v = $urandom(32'd20240611);

    repeat (5) @(negedge sys_clk);
    check(word_vld == 1'b0, "R1 vld in reset", word_vld, 0);
    check(word_l == 16'h0 && word_r == 16'h0, "R1 words in reset", {word_l, word_r}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge sys_clk);
    check(word_vld == 1'b0 && word_l == 16'h0, "R1 after release", {15'd0, word_vld, word_l}, 0);

    // R8 / R2 extremes and sign slot
    word_case(16'h8000, 16'h7FFF, "R8 min/max");
    word_case(16'hFFFF, 16'h0000, "R8 ones/zero");
    word_case(16'h0001, 16'h4000, "R2 slot15/slot1");
    // R3 channel separation with complementary patterns
    word_case(16'hA5C3, 16'h5A3C, "R3 complement");

    // R6 partial word then restart
    base = vld_cnt;
    send_slots(16'hFFFF, 16'hFFFF, 7, 1'b1);
    send_slots(slots_to_word(16'h1234), slots_to_word(16'hFEDC), 16, 1'b1);
    expect_pair(slots_to_word(16'h1234), slots_to_word(16'hFEDC), base, "R6 restart");

    // R6 frame landing on the last slot position
    base = vld_cnt;
    send_slots(16'h0F0F, 16'hF0F0, 15, 1'b1);
    send_slots(slots_to_word(16'h8001), slots_to_word(16'h7FFE), 16, 1'b1);
    expect_pair(slots_to_word(16'h8001), slots_to_word(16'h7FFE), base, "R6 late restart");

    // R7 trailing edges without frame, R5 hold
    base = vld_cnt;
    keep_l = word_l; keep_r = word_r;
    send_slots(16'hFFFF, 16'hFFFF, 9, 1'b0);
    repeat (SETTLE) @(negedge sys_clk);
    check(vld_cnt == base, "R7 no pulse", vld_cnt, base);
    check(word_l == keep_l && word_r == keep_r, "R7 R5 outputs held", {word_l, word_r}, {keep_l, keep_r});

    // random traffic, with occasional idle gaps
    for (int k = 0; k < 24; k++) begin
      logic [15:0] rl, rr;
      rl = 16'($urandom);
      rr = 16'($urandom);
      word_case(rl, rr, "R2 random");
      if (($urandom % 4) == 0) send_slots(16'($urandom), 16'($urandom), 3, 1'b0);
    end

    check(wide_cnt == 0, "R4 single-cycle strobe", wide_cnt, 0);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  initial begin
    #(SYS_PERIOD * 200000);
    if (!done_flag) begin
      done_flag = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

endmodule